// File: doc/BRIEF.md
# Interval Timer with One-Shot and Periodic Modes

This block counts down on a slow input tick (typically one pulse per microsecond) and raises a level interrupt when an interval has elapsed. Software programs a single trigger register that carries an enable flag, a mode flag and a reload count. The count is the interval length minus one, so a value of N produces an expiry on the N+1-th tick after programming.

In one-shot mode the timer disarms itself on expiry. In periodic mode it reloads the count and keeps running, producing an expiry every N+1 ticks. A second register reports the live count and the pending interrupt flag, and writing a one to the flag bit clears it. Both registers sit in a small window placed on the bus by a base-address parameter, so several copies can share one bus.

Top module: `ivt_timer`

## Requirements
- R1: After reset the interrupt output is low, and both the trigger register and the status register read as zero.
- R2: The trigger register is at byte address BASE_ADDR+0. Bit 31 is enable, bit 30 selects periodic mode (1) or one-shot (0), and bits [CNT_W-1:0] hold the reload count. A read returns these three fields, and bits 29 down to CNT_W are written as don't-care and read as zero.
- R3: Ticks are counted only while enable is set. With count N programmed, the interrupt becomes pending on the N+1-th tick, and a count of 0 expires on the first tick.
- R4: In one-shot mode, expiry clears the enable bit and leaves the count at 0. Further ticks change nothing and raise no new interrupt.
- R5: In periodic mode, expiry reloads the count and the enable bit stays set, so expiries repeat every N+1 ticks.
- R6: A write to the trigger register loads the count at once and discards any partial interval. If a write and a tick arrive in the same cycle, the write wins. Writing zero stops the timer.
- R7: The interrupt output is a level that stays high until the status register is written with bit 30 set. Status writes with bit 30 clear have no effect.
- R8: If an expiry happens in the same cycle as a clear write, the interrupt stays pending.
- R9: The status register is at byte address BASE_ADDR+4. It reads the pending flag in bit 30 and the current count in bits [CNT_W-1:0], with all other bits zero.
- R10: A write to any address other than the two registers changes no state.
- R11: The largest count, 2^CNT_W-1, expires after exactly 2^CNT_W ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle count pulse |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq | output | 1 | Level-high interrupt |

## Verification
The bench builds the timer with CNT_W=8, ADDR_W=8 and BASE_ADDR=0x40. The narrow count makes the full-scale interval of 256 ticks cheap to run, so the largest-count boundary is exercised exactly rather than inferred. The non-zero base moves both registers off address zero, so an address just past the window checks that the decode looks at the whole address.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
    localparam int DATA_W    = 32;
    localparam int EN_POS    = 31;
    localparam int MODE_POS  = 30;
    localparam int PEND_POS  = 30;
    localparam int OFS_TRIG  = 0;
    localparam int OFS_STAT  = 4;
    localparam int CNT_LIMIT = 29;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_TRIG = 2'd1,
        SEL_STAT = 2'd2
    } reg_sel_e;
endpackage

// File: rtl/ivt_decode.sv
module ivt_decode
    import ivt_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    output reg_sel_e          sel,
    output logic              wr_trig,
    output logic              wr_stat
);
    localparam logic [ADDR_W-1:0] A_TRIG = BASE_ADDR + ADDR_W'(OFS_TRIG);
    localparam logic [ADDR_W-1:0] A_STAT = BASE_ADDR + ADDR_W'(OFS_STAT);

    always_comb begin
        if (addr == A_TRIG)      sel = SEL_TRIG;
        else if (addr == A_STAT) sel = SEL_STAT;
        else                     sel = SEL_NONE;
        wr_trig = wr && (sel == SEL_TRIG);
        wr_stat = wr && (sel == SEL_STAT);
    end
endmodule

// File: rtl/ivt_counter.sv
module ivt_counter #(
    parameter int CNT_W = 29
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic             ld_en,
    input  logic             ld_per,
    input  logic [CNT_W-1:0] ld_cnt,
    output logic             en,
    output logic             per,
    output logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] cnt,
    output logic             expire
);
    typedef struct packed {
        logic             en;
        logic             per;
        logic [CNT_W-1:0] reload;
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       expire_d;

    always_comb begin
        st_d     = st_q;
        expire_d = 1'b0;
        if (load) begin
            // a software write overrides any tick in the same cycle
            st_d.en     = ld_en;
            st_d.per    = ld_per;
            st_d.reload = ld_cnt;
            st_d.cnt    = ld_cnt;
        end else if (st_q.en && tick) begin
            if (st_q.cnt == '0) begin
                expire_d = 1'b1;
                if (st_q.per) st_d.cnt = st_q.reload;
                else          st_d.en  = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en     = st_q.en;
    assign per    = st_q.per;
    assign reload = st_q.reload;
    assign cnt    = st_q.cnt;
    assign expire = expire_d;

    assert_cnt_within_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (cnt <= reload));
    assert_oneshot_disarms_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !per) |=> !en);
    assert_idle_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !load) |=> $stable(cnt));
    assert_load_immediate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == $past(ld_cnt)) && (en == $past(ld_en)));
endmodule

// File: rtl/ivt_irq.sv
module ivt_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic irq
);
    typedef struct packed {
        logic pend;
    } irq_state_t;

    irq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) st_d.pend = 1'b0;
        if (set) st_d.pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq = st_q.pend;

    assert_irq_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr) |=> irq);
    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> irq);
endmodule

// File: rtl/ivt_timer.sv
module ivt_timer
    import ivt_pkg::*;
#(
    parameter int CNT_W = 29,
    parameter int ADDR_W = 12,
    parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq
);
    reg_sel_e         sel;
    logic             wr_trig, wr_stat;
    logic             en, per, expire;
    logic [CNT_W-1:0] reload, cnt;
    logic             unused_wbits;

    assign unused_wbits = ^bus_wdata[29:CNT_W];

    ivt_decode #(
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_decode (
        .addr    (bus_addr),
        .wr      (bus_wr),
        .sel     (sel),
        .wr_trig (wr_trig),
        .wr_stat (wr_stat)
    );

    ivt_counter #(
        .CNT_W (CNT_W)
    ) u_counter (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .load   (wr_trig),
        .ld_en  (bus_wdata[EN_POS]),
        .ld_per (bus_wdata[MODE_POS]),
        .ld_cnt (bus_wdata[CNT_W-1:0]),
        .en     (en),
        .per    (per),
        .reload (reload),
        .cnt    (cnt),
        .expire (expire)
    );

    ivt_irq u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (expire),
        .clr   (wr_stat && bus_wdata[PEND_POS]),
        .irq   (irq)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (sel)
            SEL_TRIG: begin
                bus_rdata[EN_POS]     = en;
                bus_rdata[MODE_POS]   = per;
                bus_rdata[CNT_W-1:0]  = reload;
            end
            SEL_STAT: begin
                bus_rdata[PEND_POS]   = irq;
                bus_rdata[CNT_W-1:0]  = cnt;
            end
            default: bus_rdata = '0;
        endcase
    end

    assert_irq_from_expiry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(expire));
endmodule

// File: tb/ivt_timer_tb.sv
`timescale 1ns/1ps
module ivt_timer_tb;
    localparam int CNT_W  = 8;
    localparam int ADDR_W = 8;
    localparam logic [7:0] BASE = 8'h40;
    localparam logic [7:0] A_TRIG = 8'h40;
    localparam logic [7:0] A_STAT = 8'h44;
    localparam logic [7:0] A_BAD  = 8'h48;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int total = 0;
    int bad = 0;
    int tc = 0;
    int exp_q[$];
    logic irq_prev = 1'b0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    ivt_timer #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .BASE_ADDR(BASE)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = 1'b1; tc++;
            @(negedge clk);
            tick = 1'b0;
        end
    endtask

    task automatic expect_at(input int n);
        exp_q.push_back(tc + n);
    endtask

    task automatic clear_irq();
        wr(A_STAT, 32'h4000_0000);
    endtask

    // scoreboard monitor: each rising interrupt must match the queued tick index
    always @(negedge clk) begin
        if (rst_n) begin
            if (irq && !irq_prev) begin
                total++;
                if (exp_q.size() == 0) begin
                    bad++;
                    $display("FAIL R3: actual=unexpected irq at tick %0d expected=none", tc);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    if (e != tc) begin
                        bad++;
                        $display("FAIL R3/R5: actual=irq at tick %0d expected=tick %0d", tc, e);
                    end
                end
            end
            irq_prev = irq;
        end
    end

    initial begin
        #500000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 irq", {31'b0, irq}, 32'h0);
        rd(A_TRIG, v); chk("R1 trig", v, 32'h0);
        rd(A_STAT, v); chk("R1 stat", v, 32'h0);

        // R10 write outside the window is ignored
        wr(A_BAD, 32'h8000_0002);
        ticks(4);
        chk("R10 irq", {31'b0, irq}, 32'h0);
        rd(A_TRIG, v); chk("R10 trig", v, 32'h0);
        rd(A_BAD, v);  chk("R10 read", v, 32'h0);

        // R3/R4 one-shot of count 3
        wr(A_TRIG, 32'h8000_0003);
        expect_at(4);
        ticks(3);
        rd(A_STAT, v); chk("R3 before expiry", v, 32'h0);
        ticks(1);
        chk("R3 irq", {31'b0, irq}, 32'h1);
        rd(A_TRIG, v); chk("R4 enable cleared", v, 32'h0000_0003);
        rd(A_STAT, v); chk("R9 pending", v, 32'h4000_0000);
        ticks(5);
        rd(A_STAT, v); chk("R4 stays stopped", v, 32'h4000_0000);
        wr(A_STAT, 32'h0);
        chk("R7 no-clear write", {31'b0, irq}, 32'h1);
        clear_irq();
        chk("R7 cleared", {31'b0, irq}, 32'h0);
        ticks(6);
        chk("R4 no re-fire", {31'b0, irq}, 32'h0);

        // R9 live count, R6 reprogram discards partial interval
        wr(A_TRIG, 32'h8000_0009);
        ticks(3);
        rd(A_STAT, v); chk("R9 count", v, 32'h0000_0006);
        wr(A_TRIG, 32'h8000_0001);
        expect_at(2);
        ticks(2);
        chk("R6 reload", {31'b0, irq}, 32'h1);
        clear_irq();

        // R6 writing zero stops
        wr(A_TRIG, 32'h8000_0005);
        ticks(2);
        wr(A_TRIG, 32'h0);
        ticks(10);
        chk("R6 stop irq", {31'b0, irq}, 32'h0);
        rd(A_STAT, v); chk("R6 stop stat", v, 32'h0);
        rd(A_TRIG, v); chk("R6 stop trig", v, 32'h0);

        // R2 bits above the count field are dropped
        wr(A_TRIG, 32'h8000_1F05);
        rd(A_TRIG, v); chk("R2 fields", v, 32'h8000_0005);
        expect_at(6);
        ticks(6);
        chk("R2 expiry", {31'b0, irq}, 32'h1);
        clear_irq();

        // R3 count zero expires on first tick
        wr(A_TRIG, 32'h8000_0000);
        expect_at(1);
        ticks(1);
        chk("R3 zero count", {31'b0, irq}, 32'h1);
        clear_irq();

        // R5 periodic every 3 ticks
        wr(A_TRIG, 32'hC000_0002);
        rd(A_TRIG, v); chk("R2 periodic read", v, 32'hC000_0002);
        for (int k = 0; k < 3; k++) begin
            expect_at(3);
            ticks(3);
            chk("R5 period", {31'b0, irq}, 32'h1);
            clear_irq();
        end
        rd(A_TRIG, v); chk("R5 stays armed", v, 32'hC000_0002);
        wr(A_TRIG, 32'h0);

        // R8 expiry collides with clear
        wr(A_TRIG, 32'hC000_0001);
        expect_at(2);
        ticks(3);
        @(negedge clk);
        tick = 1'b1; tc++;
        bus_wr = 1'b1; bus_addr = A_STAT; bus_wdata = 32'h4000_0000;
        @(negedge clk);
        tick = 1'b0; bus_wr = 1'b0;
        chk("R8 set wins", {31'b0, irq}, 32'h1);
        wr(A_TRIG, 32'h0);
        clear_irq();
        chk("R8 cleared after", {31'b0, irq}, 32'h0);

        // R11 largest count
        wr(A_TRIG, 32'h8000_00FF);
        expect_at(256);
        ticks(255);
        chk("R11 before", {31'b0, irq}, 32'h0);
        ticks(1);
        chk("R11 expiry", {31'b0, irq}, 32'h1);
        clear_irq();

        repeat (2) @(negedge clk);
        chk("R3 all expiries seen", exp_q.size(), 32'h0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule